// File: doc/BRIEF.md
# Transmit Front-End Enable Sequencer

This block orders the start of a transmission in a low-rate radio transceiver. While the transceiver sits in its PLL-locked idle state, a one-cycle trigger from software starts a transmit burst. The block then counts microseconds on a tick input. It raises the internal PA, the internal PA buffer and a differential enable pair for an external power amplifier at programmable points. It strobes modulation start a fixed 16 microseconds after the trigger.

Two 2-bit lead-time codes choose how early the PA buffer and the external PA pair switch on before modulation. Each code is captured when the trigger is accepted. An end-of-frame input ends the burst: it brings the state back to PLL-locked idle and drops every enable together. Outside a burst the external pair rests at low/low, so no current flows into an external front-end during sleep.

Top module: `txfe_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `trx_state` is 2'b00 (off) and `mod_start`, `pa_en`, `pa_buf_en`, `ext_pa_p` and `ext_pa_n` are all low.
- R2: `trx_state` uses 2'b00 for off, 2'b01 for PLL-locked idle and 2'b10 for busy transmitting, and never shows 2'b11. Off moves to idle on the clock after `pll_ready` is seen high. Idle moves back to off on the clock after `pll_ready` is seen low.
- R3: A `tx_trig` seen in idle with `pll_ready` high moves the state to busy on the next clock. A trigger in off, or a second trigger during busy, changes nothing.
- R4: `mod_start` is high for exactly one cycle per burst. That cycle is the first one in which 16 `us_tick` pulses have been counted since the trigger was accepted.
- R5: `pa_en` (internal PA) is high during busy once at least 15 ticks have been counted.
- R6: `pa_buf_en` is high during busy once at least 16 − 2·(code+1) ticks have been counted. The code is `buf_lead`, so codes 0..3 select a lead of 2, 4, 6 or 8 µs.
- R7: `ext_pa_p` is high during busy once at least 16 − 2·(code+1) ticks have been counted, using the `ext_lead` code. `ext_pa_n` stays low, so high/low means transmit and low/low means idle. Both pins are low whenever the state is not busy.
- R8: The lead codes are sampled on the clock that accepts the trigger. Changes to `buf_lead` or `ext_lead` during busy have no effect on that burst.
- R9: `frame_end` seen during busy returns the state to idle on the next clock. On that same clock `pa_en`, `pa_buf_en` and `ext_pa_p` go low. `frame_end` outside busy is ignored, and it takes priority over a modulation start due on the same edge.
- R10: After modulation start the tick count saturates, and all enables stay high until `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| pll_ready | input | 1 | PLL locked on the channel |
| tx_trig | input | 1 | Transmit start request |
| frame_end | input | 1 | End of the transmitted frame |
| buf_lead | input | 2 | PA buffer lead-time code |
| ext_lead | input | 2 | External PA pair lead-time code |
| trx_state | output | 2 | Transceiver state code |
| mod_start | output | 1 | Modulation start strobe |
| pa_buf_en | output | 1 | Internal PA buffer enable |
| pa_en | output | 1 | Internal PA enable |
| ext_pa_p | output | 1 | External PA pair, positive pin |
| ext_pa_n | output | 1 | External PA pair, negative pin |

## Verification
The assertions assume that every input is synchronous to `clk`, that `us_tick` is a single-cycle pulse, and that the longest lead (8 µs) is shorter than the 16 µs modulation delay, so all enables are already on when modulation starts. The stimulus changes inputs just after the rising edge. It produces ticks as isolated one-cycle pulses every ten clocks. It draws the lead codes over their full 2-bit range, so any code keeps the turn-on points inside the 16 µs window.

// File: rtl/txfe_seq.sv
module txfe_seq #(
  parameter int MOD_US       = 16,
  parameter int LEAD_W       = 2,
  parameter int LEAD_STEP_US = 2,
  parameter int PA_LEAD_US   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              pll_ready,
  input  logic              tx_trig,
  input  logic              frame_end,
  input  logic [LEAD_W-1:0] buf_lead,
  input  logic [LEAD_W-1:0] ext_lead,
  output logic [1:0]        trx_state,
  output logic              mod_start,
  output logic              pa_buf_en,
  output logic              pa_en,
  output logic              ext_pa_p,
  output logic              ext_pa_n
);
  localparam int CW = $clog2(MOD_US + 1);
  localparam logic [1:0] S_OFF  = 2'b00;
  localparam logic [1:0] S_IDLE = 2'b01;
  localparam logic [1:0] S_BUSY = 2'b10;
  localparam logic [CW-1:0] MOD_CNT = CW'(MOD_US);
  localparam logic [CW-1:0] PA_THR  = CW'(MOD_US - PA_LEAD_US);

  logic [1:0]        st;
  logic [CW-1:0]     cnt;
  logic [LEAD_W-1:0] buf_q, ext_q;
  logic              mod_q;
  logic              busy;

  function automatic logic [CW-1:0] thr(input logic [LEAD_W-1:0] code);
    int lead;
    lead = LEAD_STEP_US * (int'(code) + 1);
    return (lead >= MOD_US) ? '0 : CW'(MOD_US - lead);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      buf_q <= '0;
      ext_q <= '0;
      mod_q <= 1'b0;
    end else begin
      mod_q <= 1'b0;
      case (st)
        S_OFF:
          if (pll_ready) st <= S_IDLE;
        S_IDLE:
          if (!pll_ready) st <= S_OFF;
          else if (tx_trig) begin
            st    <= S_BUSY;
            cnt   <= '0;
            buf_q <= buf_lead;
            ext_q <= ext_lead;
          end
        S_BUSY:
          if (frame_end) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else if (us_tick && cnt != MOD_CNT) begin
            cnt <= cnt + 1'b1;
            if (cnt == MOD_CNT - 1'b1) mod_q <= 1'b1;
          end
        default:
          st <= S_OFF;
      endcase
    end
  end

  assign busy      = (st == S_BUSY);
  assign trx_state = st;
  assign mod_start = mod_q;
  assign pa_en     = busy && (cnt >= PA_THR);
  assign pa_buf_en = busy && (cnt >= thr(buf_q));
  assign ext_pa_p  = busy && (cnt >= thr(ext_q));
  assign ext_pa_n  = 1'b0;
endmodule

// File: rtl/txfe_seq_chk.sv
module txfe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_ready,
  input logic       tx_trig,
  input logic       frame_end,
  input logic [1:0] trx_state,
  input logic       mod_start,
  input logic       pa_buf_en,
  input logic       pa_en,
  input logic       ext_pa_p,
  input logic       ext_pa_n
);
  p_legal_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trx_state != 2'b11);

  p_off_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trx_state == 2'b00 && !pll_ready) |=> trx_state == 2'b00);

  p_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trx_state == 2'b01 && pll_ready && tx_trig) |=> trx_state == 2'b10);

  p_mod_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |=> !mod_start);

  p_mod_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> trx_state == 2'b10);

  p_ext_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pa_p |-> (trx_state == 2'b10 && !ext_pa_n));

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trx_state == 2'b10 && frame_end) |=>
      (trx_state == 2'b01 && !pa_en && !pa_buf_en && !ext_pa_p));

  p_all_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> (pa_en && pa_buf_en && ext_pa_p));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trx_state == 2'b10 && pa_buf_en && !frame_end) |=> pa_buf_en);
endmodule

bind txfe_seq txfe_seq_chk u_chk (.*);

// File: tb/txfe_seq_test.sv
`timescale 1ns/100ps
module txfe_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic us_tick = 1'b0, pll_ready = 1'b0, tx_trig = 1'b0, frame_end = 1'b0;
  logic [1:0] buf_lead = '0, ext_lead = '0;
  logic [1:0] trx_state;
  logic mod_start, pa_buf_en, pa_en, ext_pa_p, ext_pa_n;

  int checks = 0, errors = 0, cyc = 0, div = 0;
  int m_st = 0, m_cnt = 0, m_b = 0, m_e = 0;
  bit m_mod = 0, live_chk = 0, done = 0;

  always #2.5 clk = ~clk;

  txfe_seq uut (.*);

  function automatic bit on_at(int cnt, int code);
    return cnt >= 16 - 2 * (code + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #1;
    div = (div == 9) ? 0 : div + 1;
    us_tick = (div == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_mod <= 0; m_b <= 0; m_e <= 0;
    end else begin
      m_mod <= 0;
      case (m_st)
        0: if (pll_ready) m_st <= 1;
        1: if (!pll_ready) m_st <= 0;
           else if (tx_trig) begin
             m_st <= 2; m_cnt <= 0; m_b <= int'(buf_lead); m_e <= int'(ext_lead);
           end
        default:
           if (frame_end) begin m_st <= 1; m_cnt <= 0; end
           else if (us_tick && m_cnt < 16) begin
             m_cnt <= m_cnt + 1;
             if (m_cnt == 15) m_mod <= 1;
           end
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (live_chk) begin
      chk("R2 state", int'(trx_state), m_st);
      chk("R4 mod_start", int'(mod_start), int'(m_mod));
      chk("R5 pa_en", int'(pa_en), int'(m_st == 2 && m_cnt >= 15));
      chk("R6 pa_buf_en", int'(pa_buf_en), int'(m_st == 2 && on_at(m_cnt, m_b)));
      chk("R7 ext_pa_p", int'(ext_pa_p), int'(m_st == 2 && on_at(m_cnt, m_e)));
      chk("R7 ext_pa_n", int'(ext_pa_n), 0);
    end
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_cnt(input int n);
    while (!(m_st == 2 && m_cnt == n)) @(negedge clk);
  endtask

  initial begin
    step(3);
    @(negedge clk);
    chk("R1 reset state", int'(trx_state), 0);
    chk("R1 reset enables", int'({mod_start, pa_en, pa_buf_en, ext_pa_p, ext_pa_n}), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    live_chk = 1;
    @(negedge clk);
    chk("R1 first cycle", int'(trx_state), 0);

    // trigger while off is ignored
    @(posedge clk); #1; tx_trig = 1'b1;
    step(2); tx_trig = 1'b0;
    @(negedge clk);
    chk("R3 trigger in off", int'(trx_state), 0);

    @(posedge clk); #1; pll_ready = 1'b1;
    step(2);
    @(negedge clk);
    chk("R2 reach idle", int'(trx_state), 1);

    // frame_end in idle is ignored
    @(posedge clk); #1; frame_end = 1'b1;
    step(1); frame_end = 1'b0;
    @(negedge clk);
    chk("R9 frame_end in idle", int'(trx_state), 1);

    // burst with ext code 0, buf code 3; leads changed mid-burst
    @(posedge clk); #1; ext_lead = 2'd0; buf_lead = 2'd3; tx_trig = 1'b1;
    step(1); tx_trig = 1'b0; ext_lead = 2'd3; buf_lead = 2'd0;
    @(negedge clk);
    chk("R3 busy after trigger", int'(trx_state), 2);
    @(posedge clk); #1; tx_trig = 1'b1;
    step(1); tx_trig = 1'b0;
    wait_cnt(10);
    chk("R8 ext lead latched", int'(ext_pa_p), 0);
    chk("R8 buf lead latched", int'(pa_buf_en), 1);
    chk("R3 second trigger ignored", int'(m_cnt), 10);
    wait_cnt(16);
    step(40);
    @(negedge clk);
    chk("R10 buffer held", int'(pa_buf_en), 1);
    chk("R10 pair held", int'(ext_pa_p), 1);
    @(posedge clk); #1; frame_end = 1'b1;
    step(1); frame_end = 1'b0;
    @(negedge clk);
    chk("R9 back to idle", int'(trx_state), 1);
    chk("R9 enables low", int'({pa_en, pa_buf_en, ext_pa_p}), 0);

    // frame_end aborts before modulation
    @(posedge clk); #1; tx_trig = 1'b1; ext_lead = 2'd3;
    step(1); tx_trig = 1'b0;
    wait_cnt(9);
    chk("R7 pair on at 8us lead", int'(ext_pa_p), 1);
    @(posedge clk); #1; frame_end = 1'b1;
    step(1); frame_end = 1'b0;
    @(negedge clk);
    chk("R9 abort", int'(trx_state), 1);

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 40000; i++) begin
      @(posedge clk); #1;
      pll_ready = ($urandom % 64) != 0;
      tx_trig   = ($urandom % 40) == 0;
      frame_end = ($urandom % 300) == 0;
      buf_lead  = 2'($urandom);
      ext_lead  = 2'($urandom);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule